// File: doc/BRIEF.md
# System Reset Control Port

This block is one byte-wide I/O register that software writes to ask for a platform reset and to choose which kind of reset follows. A write that sets the trigger bit (bit 2) sends out a single-cycle reset request and leaves the stored value as it was. Any other write keeps only the reset-kind bit (bit 1) and clears every other bit. A read returns the stored byte. The block does not sequence the platform reset. It hands the request pulse and the selected kind to the logic that does.

The register decodes one I/O address, set by a parameter with a default of 0x0CF9. It answers only byte-wide accesses at that address. The stored kind bit drives the `reset_type` output: 1 selects a hard reset and 0 a soft reset.

Top module: `rst_ctl_reg`

## Requirements
- R1: After a synchronous reset the stored byte is 0x00, `reset_req` is 0 and `reset_type` is 0.
- R2: A selected write whose data has bit 2 set drives `reset_req` high for exactly the one cycle after the write edge. In every other cycle `reset_req` is low.
- R3: A selected write whose data has bit 2 set leaves the stored byte unchanged.
- R4: A selected write whose data has bit 2 clear stores `wdata & 0x02`. Bit 1 is kept and every other bit is stored as 0.
- R5: While a selected read is presented, `io_rdata` shows the stored byte in the same cycle. When no selected read is presented, `io_rdata` is 0x00.
- R6: `reset_type` equals stored bit 1, where 1 means hard reset and 0 means soft reset.
- R7: A write to any other address, or with `io_width` not equal to 0 (byte), changes neither the stored byte nor `reset_req`. The width codes are 0 for byte, 1 for word and 2 for dword.
- R8: A selected read does not change the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W (16) | I/O address of the access |
| io_width | input | 2 | Access width: 0 byte, 1 word, 2 dword |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; 0x00 when not selected |
| reset_req | output | 1 | One-cycle reset request |
| reset_type | output | 1 | Selected reset kind: 1 hard, 0 soft |

## Verification
A write is captured at a rising edge. Its results are due in the cycle that follows that edge: the `reset_req` pulse, the new stored byte and the new `reset_type`. `reset_req` must then be low again one cycle later.

Reads are combinational, so `io_rdata` is due in the same cycle as the read strobe. The bench checks it a short delay after driving the strobe, well before the next edge.

The bench drives every input on falling edges. It samples the registered results on the falling edge that follows the capturing rising edge, half a period after they change and half a period before they could change again.

// File: rtl/rst_ctl_pkg.sv
package rst_ctl_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned TRIG_POS = 2;
    localparam int unsigned KIND_POS = 1;
    localparam logic [15:0] DEFAULT_PORT = 16'h0CF9;

    typedef logic [DATA_W-1:0] io_byte_t;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2
    } acc_width_e;

    typedef enum logic {
        KIND_SOFT = 1'b0,
        KIND_HARD = 1'b1
    } reset_kind_e;

    localparam io_byte_t KEEP_MASK = io_byte_t'(1) << KIND_POS;

    function automatic logic is_trigger(input io_byte_t b);
        return b[TRIG_POS];
    endfunction

    function automatic io_byte_t keep_bits(input io_byte_t b);
        return b & KEEP_MASK;
    endfunction

endpackage

// File: rtl/rst_ctl_decode.sv
module rst_ctl_decode
    import rst_ctl_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(DEFAULT_PORT)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        width,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_sel,
    output logic              rd_sel
);
    logic hit;

    always_comb begin
        hit    = (addr == PORT_ADDR) && (acc_width_e'(width) == ACC_BYTE);
        wr_sel = hit && wr;
        rd_sel = hit && rd;
    end
endmodule

// File: rtl/rst_ctl_store.sv
module rst_ctl_store
    import rst_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_sel,
    input  io_byte_t wdata,
    output io_byte_t stored,
    output logic     fire
);
    always_comb fire = wr_sel && is_trigger(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            stored <= '0;
        end else if (wr_sel && !is_trigger(wdata)) begin
            stored <= keep_bits(wdata);
        end
    end
endmodule

// File: rtl/rst_ctl_pulse.sv
module rst_ctl_pulse (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= fire;
    end
endmodule

// File: rtl/rst_ctl_reg.sv
module rst_ctl_reg
    import rst_ctl_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(DEFAULT_PORT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_width,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              reset_req,
    output logic              reset_type
);
    logic        wr_sel, rd_sel, fire;
    io_byte_t    stored;
    reset_kind_e kind;

    rst_ctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
        .addr(io_addr), .width(io_width), .wr(io_wr), .rd(io_rd),
        .wr_sel(wr_sel), .rd_sel(rd_sel)
    );

    rst_ctl_store u_store (
        .clk(clk), .rst(rst), .wr_sel(wr_sel), .wdata(io_wdata),
        .stored(stored), .fire(fire)
    );

    rst_ctl_pulse u_pulse (
        .clk(clk), .rst(rst), .fire(fire), .pulse(reset_req)
    );

    always_comb begin
        kind       = reset_kind_e'(stored[KIND_POS]);
        reset_type = (kind == KIND_HARD);
        io_rdata   = rd_sel ? stored : '0;
    end
endmodule

// File: rtl/rst_ctl_reg_chk.sv
module rst_ctl_reg_chk #(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic [1:0]        io_width,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              reset_req,
    input logic              reset_type
);
    logic sel;
    assign sel = (io_addr == PORT_ADDR) && (io_width == 2'd0);

    // R2: a trigger write yields a request in the next cycle
    a_r2_req_after_trig: assert property (@(posedge clk) disable iff (rst)
        (sel && io_wr && io_wdata[2]) |=> reset_req);

    // R2 and R7: a request only ever follows a selected trigger write
    a_r2_req_only_trig: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(sel && io_wr && io_wdata[2]));

    // R3: a trigger write keeps the reset kind
    a_r3_trig_keeps: assert property (@(posedge clk) disable iff (rst)
        (sel && io_wr && io_wdata[2]) |=> $stable(reset_type));

    // R4: a plain write takes the kind bit from the data
    a_r4_kind_stored: assert property (@(posedge clk) disable iff (rst)
        (sel && io_wr && !io_wdata[2]) |=> (reset_type == $past(io_wdata[1])));

    // R7 and R8: without a selected write the kind does not move
    a_r7_no_write_stable: assert property (@(posedge clk) disable iff (rst)
        !(sel && io_wr) |=> $stable(reset_type));

    // R5 and R4: only bit 1 of the read data can ever be set
    a_r5_read_masked: assert property (@(posedge clk) disable iff (rst)
        (io_rdata & 8'hFD) == 8'h00);

    // R5 and R6: a selected read shows the kind bit
    a_r6_read_kind: assert property (@(posedge clk) disable iff (rst)
        (sel && io_rd) |-> (io_rdata[1] == reset_type));

    // R5: an unselected read returns zero
    a_r5_unsel_zero: assert property (@(posedge clk) disable iff (rst)
        !(sel && io_rd) |-> (io_rdata == 8'h00));
endmodule

bind rst_ctl_reg rst_ctl_reg_chk #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_chk (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_width(io_width),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .reset_req(reset_req), .reset_type(reset_type)
);

// File: tb/sim_rst_ctl_reg.sv
`timescale 1ns/1ps
module sim_rst_ctl_reg;
    localparam logic [15:0] PORT = 16'h0CF9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_width = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        reset_req;
    logic        reset_type;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;
    logic [7:0]  exp_store = 8'h00;

    always #10 clk = ~clk;

    rst_ctl_reg u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_width(io_width),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .reset_req(reset_req), .reset_type(reset_type)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one write on a falling edge; results sampled on the following falling edge
    task automatic do_write(input logic [15:0] a, input logic [1:0] w, input logic [7:0] d);
        logic sel;
        logic trig;
        sel  = (a == PORT) && (w == 2'd0);
        trig = sel && d[2];
        @(negedge clk);
        io_addr = a; io_width = w; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (sel && !d[2]) exp_store = d & 8'h02;
        check(trig ? "R2 req pulse" : "R7 no req", {7'b0, reset_req}, {7'b0, trig});
        check(d[2] ? "R3 kind kept" : "R4 R6 kind", {7'b0, reset_type}, {7'b0, exp_store[1]});
        @(negedge clk);
        check("R2 req one cycle", {7'b0, reset_req}, 8'h00);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] w, input string req);
        logic sel;
        sel = (a == PORT) && (w == 2'd0);
        @(negedge clk);
        io_addr = a; io_width = w; io_rd = 1'b1;
        #2;
        check(req, io_rdata, sel ? exp_store : 8'h00);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 req", {7'b0, reset_req}, 8'h00);
        check("R1 kind", {7'b0, reset_type}, 8'h00);
        do_read(PORT, 2'd0, "R1 read");

        // full sweep of write data at the selected port
        for (int v = 0; v < 256; v++) begin
            do_write(PORT, 2'd0, 8'(v));
            do_read(PORT, 2'd0, "R5 R4 R3 read");
        end

        // R8: repeated reads leave the value
        do_write(PORT, 2'd0, 8'hFB);
        for (int k = 0; k < 4; k++) do_read(PORT, 2'd0, "R8 read stable");
        check("R6 hard", {7'b0, reset_type}, 8'h01);

        // R7: other addresses and widths are ignored
        for (int k = 0; k < 4; k++) begin
            do_write(PORT ^ (16'h1 << k), 2'd0, 8'h04);
            do_write(PORT ^ (16'h1 << k), 2'd0, 8'h00);
            do_read(PORT ^ (16'h1 << k), 2'd0, "R5 R7 other addr");
        end
        for (int w = 1; w < 4; w++) begin
            do_write(PORT, 2'(w), 8'h00);
            do_write(PORT, 2'(w), 8'h04);
            do_read(PORT, 2'(w), "R5 R7 other width");
        end
        do_read(PORT, 2'd0, "R7 value kept");

        // R2: back-to-back trigger writes, one pulse each
        @(negedge clk);
        io_addr = PORT; io_width = 2'd0; io_wdata = 8'h06; io_wr = 1'b1;
        @(negedge clk);
        check("R2 first pulse", {7'b0, reset_req}, 8'h01);
        io_wdata = 8'h00;
        @(negedge clk);
        io_wr = 1'b0;
        exp_store = 8'h00;
        check("R2 second write plain", {7'b0, reset_req}, 8'h00);
        check("R4 soft", {7'b0, reset_type}, 8'h00);

        // R1: reset clears a hard setting
        do_write(PORT, 2'd0, 8'h02);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        exp_store = 8'h00;
        check("R1 kind after reset", {7'b0, reset_type}, 8'h00);
        do_read(PORT, 2'd0, "R1 read after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule